// File: doc/BRIEF.md
# Scrambled Single-Port Memory Wrapper

This block wraps a small single-port storage array so that neither the row a word lands in nor the bits stored there match what the requester sees. A request is granted in the same cycle only while the key-valid flag is high. The logical word address is pushed through a nonce-keyed substitution-permutation network (SPN) to select the physical row. Each data chunk is first diffused by an unkeyed SPN and then XORed with a keystream block. An outside cipher produces that keystream from an IV that the wrapper drives: the upper nonce bits followed by the logical word address.

One parity bit per byte is computed over the plaintext and kept next to the scrambled data. A per-byte write mask lets single bytes change without a read-modify-write. Reads return one cycle after the grant. The keystream and the inverse diffusion are applied on the way out, and the parity is checked again. A byte whose parity fails raises the uncorrectable error bit, and the failing address is reported. If the key or nonce changes between a write and a read, the data comes back as garbage and usually flags parity errors. The array needs no clearing for that to happen.

Top module: `scr_sram_wrap`

## Requirements
- R1: `gnt_o` equals `req_i AND key_valid_i` in the same cycle. A request while `key_valid_i` is low changes no stored bit and produces no read response.
- R2: `iv_o` equals `{nonce_i[63:4], addr_i}` (nonce bits above the address width, then the logical word address), combinationally.
- R3: A granted write stores, per 8-bit chunk, SPN(chunk, key 0) XOR the matching bits of `ks_i` (bits 0..31 for a 32-bit word, upper keystream bits unused). A granted read XORs the keystream given at that read's grant and applies the inverse SPN, so the same nonce and keystream function return the written word.
- R4: `rvalid_o` is high exactly in the cycle after a granted read, with `rdata_o` valid in that cycle. Writes and idle cycles leave `rvalid_o` low.
- R5: `wmask_i` bit b enables byte b (bits 8b+7..8b). Bytes whose mask bit is 0 keep their stored data and parity.
- R6: The physical row is SPN(addr_i, nonce_i[3:0]). The SPN of width w with key k runs two rounds. Each round: XOR k; replace every whole nibble x by S(x), with S = C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2 for x = 0..15; reverse the bit order; move bit 2i to position i and bit 2i+1 to position w/2+i. A last XOR with k follows the second round. Changing the low nonce bits therefore moves logical words to other rows.
- R7: The stored parity bit of byte b is the XOR of the plaintext byte. On a read, `rerror_o[1]` is high with `rvalid_o` when any descrambled byte's XOR differs from its stored bit. `rerror_o[0]` is always 0.
- R8: `raddr_o` shows the logical address of a read in the cycle its `rerror_o[1]` is high, and holds that value until the next failing read.
- R9: During and right after reset, `gnt_o` (with no request), `rvalid_o`, `rerror_o` and `raddr_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| key_valid_i | input | 1 | Key and nonce usable; gates grants |
| nonce_i | input | 64 | Low ADDR_W bits key the address SPN, the rest forms the IV prefix |
| iv_o | output | 64 | IV for the external keystream source |
| ks_i | input | 64 | Keystream block for the current `iv_o` |
| req_i | input | 1 | Access request |
| gnt_o | output | 1 | Request accepted this cycle |
| write_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Logical word address |
| wdata_i | input | 32 | Write data |
| wmask_i | input | 4 | Per-byte write enable |
| rdata_o | output | 32 | Descrambled read data |
| rvalid_o | output | 1 | Read data valid |
| rerror_o | output | 2 | Bit 1 uncorrectable parity error, bit 0 correctable (always 0) |
| raddr_o | output | 4 | Logical address of the last failing read |

## Verification
A wrong physical row or a wrong keystream bit shows up in the very next read response as data that differs from the arithmetic model. It usually also raises a parity error on that same beat. A stale keystream register or a misordered diffusion step corrupts every byte it touches on the first read after the write, so full-address sweeps under several nonces expose it within a few dozen cycles. A mask fault shows on the read right after each masked write. A fault in error or address reporting shows in the same response cycle, or as a `raddr_o` that moves without an error.

// File: rtl/scr_sram_pkg.sv
package scr_sram_pkg;

  // 4-bit substitution used by every SPN layer
  function automatic logic [3:0] sbox4(input logic [3:0] x);
    logic [3:0] y;
    case (x)
      4'h0: y = 4'hC;  4'h1: y = 4'h5;  4'h2: y = 4'h6;  4'h3: y = 4'hB;
      4'h4: y = 4'h9;  4'h5: y = 4'h0;  4'h6: y = 4'hA;  4'h7: y = 4'hD;
      4'h8: y = 4'h3;  4'h9: y = 4'hE;  4'hA: y = 4'hF;  4'hB: y = 4'h8;
      4'hC: y = 4'h4;  4'hD: y = 4'h7;  4'hE: y = 4'h1;  default: y = 4'h2;
    endcase
    return y;
  endfunction

  function automatic logic [3:0] sbox4_inv(input logic [3:0] x);
    logic [3:0] y;
    case (x)
      4'h0: y = 4'h5;  4'h1: y = 4'hE;  4'h2: y = 4'hF;  4'h3: y = 4'h8;
      4'h4: y = 4'hC;  4'h5: y = 4'h1;  4'h6: y = 4'h2;  4'h7: y = 4'hD;
      4'h8: y = 4'hB;  4'h9: y = 4'h4;  4'hA: y = 4'h6;  4'hB: y = 4'h3;
      4'hC: y = 4'h0;  4'hD: y = 4'h7;  4'hE: y = 4'h9;  default: y = 4'hA;
    endcase
    return y;
  endfunction

  // parity bit kept beside each plaintext byte
  function automatic logic byte_par(input logic [7:0] b);
    return ^b;
  endfunction

endpackage

// File: rtl/scr_spn.sv
module scr_spn #(
  parameter int W       = 8,
  parameter int ROUNDS  = 2,
  parameter bit INVERSE = 1'b0
) (
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] key_i,
  output logic [W-1:0] data_o
);
  import scr_sram_pkg::*;

  localparam int NNIB = W / 4;
  localparam int HALF = W / 2;

  function automatic logic [W-1:0] sub_layer(input logic [W-1:0] s, input bit inv);
    logic [W-1:0] r;
    r = s;
    for (int n = 0; n < NNIB; n++) begin
      r[4*n +: 4] = inv ? sbox4_inv(s[4*n +: 4]) : sbox4(s[4*n +: 4]);
    end
    return r;
  endfunction

  function automatic logic [W-1:0] flip_bits(input logic [W-1:0] s);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = s[W-1-i];
    return r;
  endfunction

  function automatic logic [W-1:0] perm_fwd(input logic [W-1:0] s);
    logic [W-1:0] r;
    r = s;
    for (int i = 0; i < HALF; i++) begin
      r[i]        = s[2*i];
      r[i + HALF] = s[2*i + 1];
    end
    return r;
  endfunction

  function automatic logic [W-1:0] perm_inv(input logic [W-1:0] s);
    logic [W-1:0] r;
    r = s;
    for (int i = 0; i < HALF; i++) begin
      r[2*i]     = s[i];
      r[2*i + 1] = s[i + HALF];
    end
    return r;
  endfunction

  generate
    if (ROUNDS == 0) begin : g_bypass
      logic unused_key;
      assign unused_key = ^key_i;
      assign data_o = data_i;
    end else if (!INVERSE) begin : g_fwd
      always_comb begin
        logic [W-1:0] s;
        s = data_i;
        for (int r = 0; r < ROUNDS; r++) begin
          s = perm_fwd(flip_bits(sub_layer(s ^ key_i, 1'b0)));
        end
        data_o = s ^ key_i;
      end
    end else begin : g_inv
      always_comb begin
        logic [W-1:0] s;
        s = data_i ^ key_i;
        for (int r = 0; r < ROUNDS; r++) begin
          s = sub_layer(flip_bits(perm_inv(s)), 1'b1) ^ key_i;
        end
        data_o = s;
      end
    end
  endgenerate

endmodule

// File: rtl/scr_ram_array.sv
module scr_ram_array #(
  parameter int DEPTH  = 16,
  parameter int NLANE  = 4,
  parameter int LANE_W = 8
) (
  input  logic                      clk_i,
  input  logic                      en_i,
  input  logic                      we_i,
  input  logic [$clog2(DEPTH)-1:0]  addr_i,
  input  logic [NLANE-1:0]          be_i,
  input  logic [NLANE*LANE_W-1:0]   wdata_i,
  input  logic [NLANE-1:0]          wpar_i,
  output logic [NLANE*LANE_W-1:0]   rdata_o,
  output logic [NLANE-1:0]          rpar_o
);

  generate
    for (genvar l = 0; l < NLANE; l++) begin : g_lane
      logic [LANE_W:0] mem [DEPTH];
      logic [LANE_W:0] q;

      always_ff @(posedge clk_i) begin
        if (en_i && we_i && be_i[l]) mem[addr_i] <= {wpar_i[l], wdata_i[l*LANE_W +: LANE_W]};
        if (en_i && !we_i)           q <= mem[addr_i];
      end

      assign rdata_o[l*LANE_W +: LANE_W] = q[LANE_W-1:0];
      assign rpar_o[l]                   = q[LANE_W];
    end
  endgenerate

endmodule

// File: rtl/scr_sram_wrap.sv
module scr_sram_wrap #(
  parameter int DEPTH       = 16,
  parameter int DATA_W      = 32,
  parameter int CHUNK_W     = 8,
  parameter int DIFF_ROUNDS = 2,
  parameter int ADDR_ROUNDS = 2,
  parameter int KS_W        = 64
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      key_valid_i,
  input  logic [KS_W-1:0]           nonce_i,
  output logic [KS_W-1:0]           iv_o,
  input  logic [KS_W-1:0]           ks_i,
  input  logic                      req_i,
  output logic                      gnt_o,
  input  logic                      write_i,
  input  logic [$clog2(DEPTH)-1:0]  addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  input  logic [DATA_W/8-1:0]       wmask_i,
  output logic [DATA_W-1:0]         rdata_o,
  output logic                      rvalid_o,
  output logic [1:0]                rerror_o,
  output logic [$clog2(DEPTH)-1:0]  raddr_o
);
  import scr_sram_pkg::*;

  localparam int ADDR_W = $clog2(DEPTH);
  localparam int NBYTES = DATA_W / 8;
  localparam int NCHUNK = DATA_W / CHUNK_W;

  // named events for the checker
  logic wr_fire, rd_fire, par_err;
  logic [ADDR_W-1:0] phys_addr;
  logic [DATA_W-1:0] ks_w, ks_q;
  logic [DATA_W-1:0] wdata_diff, wcipher;
  logic [DATA_W-1:0] ram_rdata, rd_mix, rd_plain;
  logic [NBYTES-1:0] wpar, ram_rpar, par_mismatch;
  logic              rvalid_q;
  logic [ADDR_W-1:0] rd_addr_q, fail_addr_q;

  assign gnt_o   = req_i & key_valid_i;
  assign wr_fire = gnt_o & write_i;
  assign rd_fire = gnt_o & ~write_i;

  assign iv_o = {nonce_i[KS_W-1:ADDR_W], addr_i};

  // keystream fitted to the word width (truncated, or repeated if wider)
  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_ks
      assign ks_w[i] = ks_i[i % KS_W];
    end
    if (DATA_W < KS_W) begin : g_ks_unused
      logic unused_ks_hi;
      assign unused_ks_hi = ^ks_i[KS_W-1:DATA_W];
    end
  endgenerate

  scr_spn #(.W(ADDR_W), .ROUNDS(ADDR_ROUNDS), .INVERSE(1'b0)) u_addr_spn (
    .data_i (addr_i),
    .key_i  (nonce_i[ADDR_W-1:0]),
    .data_o (phys_addr)
  );

  generate
    for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
      scr_spn #(.W(CHUNK_W), .ROUNDS(DIFF_ROUNDS), .INVERSE(1'b0)) u_diff (
        .data_i (wdata_i[c*CHUNK_W +: CHUNK_W]),
        .key_i  ({CHUNK_W{1'b0}}),
        .data_o (wdata_diff[c*CHUNK_W +: CHUNK_W])
      );
      scr_spn #(.W(CHUNK_W), .ROUNDS(DIFF_ROUNDS), .INVERSE(1'b1)) u_undiff (
        .data_i (rd_mix[c*CHUNK_W +: CHUNK_W]),
        .key_i  ({CHUNK_W{1'b0}}),
        .data_o (rd_plain[c*CHUNK_W +: CHUNK_W])
      );
    end
    for (genvar b = 0; b < NBYTES; b++) begin : g_par
      assign wpar[b]         = byte_par(wdata_i[8*b +: 8]);
      assign par_mismatch[b] = byte_par(rd_plain[8*b +: 8]) ^ ram_rpar[b];
    end
  endgenerate

  assign wcipher = wdata_diff ^ ks_w;

  scr_ram_array #(.DEPTH(DEPTH), .NLANE(NBYTES), .LANE_W(8)) u_ram (
    .clk_i   (clk_i),
    .en_i    (gnt_o),
    .we_i    (write_i),
    .addr_i  (phys_addr),
    .be_i    (wmask_i),
    .wdata_i (wcipher),
    .wpar_i  (wpar),
    .rdata_o (ram_rdata),
    .rpar_o  (ram_rpar)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q    <= 1'b0;
      ks_q        <= '0;
      rd_addr_q   <= '0;
      fail_addr_q <= '0;
    end else begin
      rvalid_q <= rd_fire;
      if (rd_fire) begin
        ks_q      <= ks_w;
        rd_addr_q <= addr_i;
      end
      if (par_err) fail_addr_q <= rd_addr_q;
    end
  end

  assign rd_mix   = ram_rdata ^ ks_q;
  assign par_err  = rvalid_q & (|par_mismatch);

  assign rdata_o  = rd_plain;
  assign rvalid_o = rvalid_q;
  assign rerror_o = {par_err, 1'b0};
  assign raddr_o  = par_err ? rd_addr_q : fail_addr_q;

endmodule

// File: rtl/scr_sram_checker.sv
module scr_sram_checker #(
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              key_valid_i,
  input logic              gnt_o,
  input logic              rd_fire,
  input logic              rvalid_o,
  input logic [1:0]        rerror_o,
  input logic [ADDR_W-1:0] raddr_o,
  input logic [ADDR_W-1:0] rd_addr_q
);

  assert_grant_gated_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_o |-> (req_i && key_valid_i));

  assert_key_blocks_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !key_valid_i) |-> !gnt_o);

  assert_read_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_fire |=> rvalid_o);

  assert_no_spurious_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_fire |=> !rvalid_o);

  assert_corr_bit_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rerror_o[0]);

  assert_error_with_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rerror_o[1] |-> rvalid_o);

  assert_fail_addr_report_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rerror_o[1] |-> (raddr_o == rd_addr_q));

  assert_fail_addr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (rerror_o[1] || $stable(raddr_o)));

endmodule

bind scr_sram_wrap scr_sram_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .key_valid_i (key_valid_i),
  .gnt_o       (gnt_o),
  .rd_fire     (rd_fire),
  .rvalid_o    (rvalid_o),
  .rerror_o    (rerror_o),
  .raddr_o     (raddr_o),
  .rd_addr_q   (rd_addr_q)
);

// File: tb/tb_scr_sram_wrap.sv
module tb_scr_sram_wrap;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 16;
  localparam int DATA_W = 32;
  localparam int AW     = 4;
  localparam int NB     = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              key_valid = 1'b0;
  logic [63:0]       nonce = '0;
  logic [63:0]       iv;
  logic [63:0]       ks;
  logic              req = 1'b0;
  logic              gnt;
  logic              wr_en = 1'b0;
  logic [AW-1:0]     addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [NB-1:0]     wmask = '0;
  logic [DATA_W-1:0] rdata;
  logic              rvalid;
  logic [1:0]        rerror;
  logic [AW-1:0]     raddr;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  // bench-side keystream source: any fixed mixing of the IV
  function automatic logic [63:0] ks_of(input logic [63:0] v);
    return (v * 64'h9E3779B97F4A7C15) ^ {v[40:0], v[63:41]};
  endfunction

  assign ks = ks_of(iv);

  always #(CLK_PERIOD/2) clk = ~clk;

  scr_sram_wrap #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .key_valid_i(key_valid), .nonce_i(nonce),
    .iv_o(iv), .ks_i(ks), .req_i(req), .gnt_o(gnt), .write_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .wmask_i(wmask), .rdata_o(rdata),
    .rvalid_o(rvalid), .rerror_o(rerror), .raddr_o(raddr)
  );

  // model of the physical array contents
  logic [DATA_W-1:0] m_d [DEPTH];
  logic [NB-1:0]     m_p [DEPTH];
  logic [AW-1:0]     fail_m = '0;

  function automatic logic [3:0] sb(input logic [3:0] x);
    logic [63:0] tbl;
    tbl = 64'hC56B90AD3EF84712;
    return tbl[60 - 4*x +: 4];
  endfunction

  // SPN of width w (<= 8), two rounds, written with destination-index arithmetic
  function automatic logic [7:0] spn_b(input logic [7:0] x, input logic [7:0] k, input int w);
    logic [7:0] s, t;
    s = x;
    for (int r = 0; r < 2; r++) begin
      s = s ^ k;
      for (int n = 0; n < w/4; n++) s[4*n +: 4] = sb(s[4*n +: 4]);
      t = s;
      for (int j = 0; j < w; j++) begin
        int f;
        int g;
        f = w - 1 - j;
        g = (f % 2 == 0) ? f/2 : w/2 + f/2;
        t[g] = s[j];
      end
      s = t;
    end
    return s ^ k;
  endfunction

  function automatic logic [7:0] undiff_b(input logic [7:0] y);
    for (int v = 0; v < 256; v++) begin
      if (spn_b(v[7:0], 8'h00, 8) == y) return v[7:0];
    end
    return 8'h00;
  endfunction

  function automatic logic [AW-1:0] phys_b(input logic [AW-1:0] a, input logic [AW-1:0] k);
    logic [7:0] r;
    r = spn_b({4'h0, a}, {4'h0, k}, AW);
    return r[AW-1:0];
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DATA_W-1:0] d, input logic [NB-1:0] m);
    logic [63:0] ivx, kx;
    logic [AW-1:0] p;
    @(negedge clk);
    req = 1'b1; wr_en = 1'b1; addr = a; wdata = d; wmask = m;
    #1;
    chk("R1", gnt, key_valid);
    ivx = {nonce[63:AW], a};
    chk("R2", iv, ivx);
    if (key_valid) begin
      kx = ks_of(ivx);
      p  = phys_b(a, nonce[AW-1:0]);
      for (int b = 0; b < NB; b++) begin
        if (m[b]) begin
          m_d[p][8*b +: 8] = spn_b(d[8*b +: 8], 8'h00, 8) ^ kx[8*b +: 8];
          m_p[p][b]        = ^d[8*b +: 8];
        end
      end
    end
    @(negedge clk);
    req = 1'b0; wr_en = 1'b0;
    chk("R4", rvalid, 1'b0);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    logic [63:0] ivx, kx;
    logic [AW-1:0] p;
    logic [DATA_W-1:0] raw, exp_d;
    logic [7:0] pb;
    logic any;
    @(negedge clk);
    req = 1'b1; wr_en = 1'b0; addr = a;
    #1;
    chk("R1", gnt, 1'b1);
    ivx = {nonce[63:AW], a};
    chk("R2", iv, ivx);
    kx  = ks_of(ivx);
    p   = phys_b(a, nonce[AW-1:0]);
    raw = m_d[p] ^ kx[DATA_W-1:0];
    any = 1'b0;
    for (int b = 0; b < NB; b++) begin
      pb = undiff_b(raw[8*b +: 8]);
      exp_d[8*b +: 8] = pb;
      if ((^pb) !== m_p[p][b]) any = 1'b1;
    end
    if (any) fail_m = a;
    @(negedge clk);
    req = 1'b0;
    chk("R4", rvalid, 1'b1);
    chk(tag, rdata, exp_d);
    chk("R7", rerror, {any, 1'b0});
    chk("R8", raddr, fail_m);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    nonce = 64'h0123_4567_89AB_CDE5;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", gnt, 1'b0);
    chk("R9", rvalid, 1'b0);
    chk("R9", rerror, 2'b00);
    chk("R9", raddr, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", rvalid, 1'b0);
    key_valid = 1'b1;

    // R3: full sweep under one nonce
    for (int a = 0; a < DEPTH; a++)
      wr(a[AW-1:0], 32'hA5C3_0F96 ^ (a * 32'h0101_0137), 4'hF);
    for (int a = 0; a < DEPTH; a++) rd(a[AW-1:0], "R3");

    // R5: every mask value on one address
    for (int m = 0; m < 16; m++) begin
      wr(4'd9, (32'h1357_9BDF * (m + 1)) ^ 32'hDEAD_BEEF, m[NB-1:0]);
      rd(4'd9, "R5");
    end

    // R1: write attempted with key invalid must not land
    key_valid = 1'b0;
    wr(4'd3, 32'hFFFF_FFFF, 4'hF);
    key_valid = 1'b1;
    rd(4'd3, "R1");

    // R7/R8: keystream prefix changed, row mapping kept
    nonce = nonce ^ 64'hFFFF_0000_0000_0000;
    for (int a = 0; a < DEPTH; a++) rd(a[AW-1:0], "R7");

    // R6: address key changed, rows move
    nonce = nonce ^ 64'h0000_0000_0000_0006;
    for (int a = 0; a < DEPTH; a++) rd(a[AW-1:0], "R6");
    for (int a = 0; a < DEPTH; a++)
      wr(a[AW-1:0], 32'h0F1E_2D3C + (a * 32'h1111_1111), 4'hF);
    for (int a = DEPTH - 1; a >= 0; a--) rd(a[AW-1:0], "R6");

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule